// File: doc/BRIEF.md
# TDM Switch Processor Access Port

This block is the parallel host port of a time-division digital switch. A host drives an address, a chip select, a data strobe and a read/write line. The block decodes each access and sends it to one of two places. The first is a bank of four configuration registers. The second is one of three per-stream channel stores: the high connection store, the low connection store and the received-data store. Channel accesses are steered indirectly. Fields of the control register choose the store and the stream subsection. The address bus supplies only the channel number.

A split setting separates the two directions of the same channel address. Reads come from the received-data store and writes land in the low connection store. A message setting in the control register is brought out as a level that tells the switching datapath to send the low connection contents on every output channel. The stream rate in the interface mode register limits how many channels of a subsection are reachable. The received-data store is loaded from the switching side through a simple fill port, and the host can only read it. Each accepted access is answered by an active-low acknowledge.

Top module: `tdm_cpu_port`

## Requirements
- R1: With address bit 5 at 0, address bits 4..0 equal to 0, 1, 2 and 3 select the control, interface mode, stream pair and frame offset registers. Bits 7 and 6 are ignored for these registers. Each register reads back the last value written to it.
- R2: With address bit 5 at 1, the channel number is {addr[7:6], addr[4:0]}. Control bits [5:4] choose the target store: 00 is the received-data store, 10 is the low connection store and 11 is the high connection store.
- R3: Control bits [1:0] choose the stream subsection. Each subsection holds 128 channels, and the subsections are independent of one another.
- R4: Host writes aimed at the received-data store are ignored, and the access is still acknowledged. That store is loaded only through the fill port, at address {stream, channel}, and the host reads the loaded value back.
- R5: While control bit 7 is 1, channel reads return the received-data store and channel writes go to the low connection store, whatever control bits [5:4] hold.
- R6: Output msg_mode equals control bit 6. It changes on the clock edge that accepts the write to the control register.
- R7: Register addresses 4 to 31 read as zero. Writes to them change nothing and are still acknowledged.
- R8: Control bits [5:4] = 01 is reserved. Channel reads with it return zero, and channel writes with it change no store.
- R9: Interface mode bits [1:0] set the channel range: 00 allows channels 0..31, 01 allows 0..63, and 10 or 11 allow 0..127. Reads outside the range return zero, and writes outside it are ignored.
- R10: An access is requested while cs_n is 0 and ds is 1. dta_n goes low after the first clock edge that sees a request while dta_n is high, and read data is valid at that moment. dta_n stays low with stable rdata while the request holds. It returns high after the first edge that sees no request. Each strobe performs one access.
- R11: A synchronous active-high reset clears all four registers, so the received-data store, stream 0 and the full-rate-independent defaults are selected, split and message are off, msg_mode is 0, and dta_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rd_wr | input | 1 | 1 for a read, 0 for a write |
| addr | input | ADDR_W | Host address |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data, valid while dta_n is low |
| dta_n | output | 1 | Access acknowledge, active low |
| msg_mode | output | 1 | Message level for all output channels |
| dm_we | input | 1 | Fill-port write enable for the received-data store |
| dm_waddr | input | STREAM_W+ADDR_W-1 | Fill-port address {stream, channel} |
| dm_wdata | input | DW | Fill-port write data |

## Verification
The same channel address is written and read under every store-select code, under two stream values and with split on and off. A value that shows up in the wrong store or stream exposes a steering fault. Register addresses are also tried with bits 7 and 6 set, and at unused offsets, to separate real decoding from aliasing. The channel limits are probed at channels 31, 40 and 100 under each rate code, so an off-by-one boundary or a missing rate check shows up as a nonzero read or a leaked write. A behavioural model in the bench follows every strobe and compares the acknowledge, msg_mode and read data on every clock.

// File: rtl/tdm_cpu_pkg.sv
package tdm_cpu_pkg;
  typedef enum logic [2:0] {SRC_ZERO, SRC_REG, SRC_DM, SRC_CL, SRC_CH} rdsrc_e;
  typedef enum logic [1:0] {WR_NONE, WR_CL, WR_CH} wrdst_e;
  localparam logic [1:0] SEL_DM  = 2'b00;
  localparam logic [1:0] SEL_RSV = 2'b01;
  localparam logic [1:0] SEL_CL  = 2'b10;
  localparam logic [1:0] SEL_CH  = 2'b11;
  localparam int CTRL_SPLIT = 7;
  localparam int CTRL_MSG   = 6;
  localparam int CTRL_SELHI = 5;
  localparam int CTRL_SELLO = 4;
  localparam int NUM_REGS   = 4;
  localparam int REG_CTRL   = 0;
  localparam int REG_IFM    = 1;
endpackage

// File: rtl/tdm_cpu_decode.sv
module tdm_cpu_decode
  import tdm_cpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 8,
  parameter int STREAM_W = 2
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DW-1:0]                ctrl,
  input  logic [DW-1:0]                ifmode,
  output logic                         is_chan,
  output logic                         reg_hit,
  output logic [1:0]                   reg_idx,
  output logic [STREAM_W+ADDR_W-2:0]   mem_addr,
  output rdsrc_e                       rd_src,
  output wrdst_e                       wr_dst
);
  localparam int CH_W = ADDR_W - 1;

  logic [CH_W-1:0]  chan;
  logic             in_range;
  logic [1:0]       sel;
  logic             split;

  assign is_chan  = addr[5];
  assign chan     = {addr[ADDR_W-1:6], addr[4:0]};
  assign mem_addr = {ctrl[STREAM_W-1:0], chan};
  assign reg_hit  = !addr[5] && (addr[4:0] < 5'(NUM_REGS));
  assign reg_idx  = addr[1:0];
  assign sel      = ctrl[CTRL_SELHI:CTRL_SELLO];
  assign split    = ctrl[CTRL_SPLIT];

  always_comb begin
    case (ifmode[1:0])
      2'b00:   in_range = (chan >> 5) == '0;
      2'b01:   in_range = (chan >> 6) == '0;
      default: in_range = 1'b1;
    endcase
  end

  always_comb begin
    if (!is_chan)       rd_src = reg_hit ? SRC_REG : SRC_ZERO;
    else if (!in_range) rd_src = SRC_ZERO;
    else if (split)     rd_src = SRC_DM;
    else begin
      case (sel)
        SEL_DM:  rd_src = SRC_DM;
        SEL_CL:  rd_src = SRC_CL;
        SEL_CH:  rd_src = SRC_CH;
        default: rd_src = SRC_ZERO;
      endcase
    end
  end

  always_comb begin
    if (!is_chan || !in_range) wr_dst = WR_NONE;
    else if (split)            wr_dst = WR_CL;
    else if (sel == SEL_CL)    wr_dst = WR_CL;
    else if (sel == SEL_CH)    wr_dst = WR_CH;
    else                       wr_dst = WR_NONE;
  end
endmodule

// File: rtl/tdm_cpu_regs.sv
module tdm_cpu_regs
  import tdm_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] ifmode
);
  logic [DW-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) regs[idx] <= wdata;
      if (re) rdata_q <= regs[idx];
    end
  end

  assign ctrl   = regs[REG_CTRL];
  assign ifmode = regs[REG_IFM];
endmodule

// File: rtl/tdm_chan_ram.sv
module tdm_chan_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tdm_cpu_port.sv
module tdm_cpu_port
  import tdm_cpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 8,
  parameter int STREAM_W = 2,
  localparam int MAW     = STREAM_W + ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ds,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              dta_n,
  output logic              msg_mode,
  input  logic              dm_we,
  input  logic [MAW-1:0]    dm_waddr,
  input  logic [DW-1:0]     dm_wdata
);
  localparam int NMEM = 3;

  logic           req, accept;
  logic           is_chan, reg_hit;
  logic [1:0]     reg_idx;
  logic [MAW-1:0] mem_addr;
  rdsrc_e         rd_src, src_q;
  wrdst_e         wr_dst;
  logic [DW-1:0]  ctrl, ifmode, reg_q;
  logic           chan_rd;
  logic [NMEM-1:0] m_we;
  logic [MAW-1:0] m_waddr [NMEM];
  logic [DW-1:0]  m_wdata [NMEM];
  logic [DW-1:0]  m_q     [NMEM];
  logic           dta_q;

  assign req     = !cs_n && ds;
  assign accept  = req && dta_q;
  assign chan_rd = accept && rd_wr && is_chan;

  tdm_cpu_decode #(.ADDR_W(ADDR_W), .DW(DW), .STREAM_W(STREAM_W)) u_dec (
    .addr(addr), .ctrl(ctrl), .ifmode(ifmode), .is_chan(is_chan),
    .reg_hit(reg_hit), .reg_idx(reg_idx), .mem_addr(mem_addr),
    .rd_src(rd_src), .wr_dst(wr_dst)
  );

  tdm_cpu_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .we(accept && !rd_wr && reg_hit),
    .re(accept && rd_wr && reg_hit),
    .idx(reg_idx), .wdata(wdata), .rdata_q(reg_q),
    .ctrl(ctrl), .ifmode(ifmode)
  );

  for (genvar g = 0; g < NMEM; g++) begin : g_mem
    if (g == 0) begin : g_fill
      assign m_we[g]    = dm_we;
      assign m_waddr[g] = dm_waddr;
      assign m_wdata[g] = dm_wdata;
    end else begin : g_host
      assign m_we[g]    = accept && !rd_wr && (wr_dst == ((g == 1) ? WR_CL : WR_CH));
      assign m_waddr[g] = mem_addr;
      assign m_wdata[g] = wdata;
    end
    tdm_chan_ram #(.DW(DW), .AW(MAW)) u_ram (
      .clk(clk), .we(m_we[g]), .waddr(m_waddr[g]), .wdata(m_wdata[g]),
      .re(chan_rd), .raddr(mem_addr), .rdata(m_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dta_q <= 1'b1;
      src_q <= SRC_ZERO;
    end else begin
      if (accept) begin
        dta_q <= 1'b0;
        if (rd_wr) src_q <= rd_src;
      end else if (!req) begin
        dta_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_REG: rdata = reg_q;
      SRC_DM:  rdata = m_q[0];
      SRC_CL:  rdata = m_q[1];
      SRC_CH:  rdata = m_q[2];
      default: rdata = '0;
    endcase
  end

  assign dta_n    = dta_q;
  assign msg_mode = ctrl[CTRL_MSG];
endmodule

// File: rtl/tdm_cpu_port_chk.sv
module tdm_cpu_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ds,
  input logic              rd_wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata,
  input logic              dta_n,
  input logic              msg_mode
);
  assert_ack_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ds && dta_n) |=> !dta_n);

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && ds) |=> dta_n);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ds && !dta_n) |=> (!dta_n && $stable(rdata)));

  assert_msg_source_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(msg_mode) |-> $past(!cs_n && ds && dta_n && !rd_wr && addr[5:0] == 6'd0));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (dta_n && !msg_mode));
endmodule

bind tdm_cpu_port tdm_cpu_port_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rd_wr(rd_wr), .addr(addr),
  .rdata(rdata), .dta_n(dta_n), .msg_mode(msg_mode)
);

// File: tb/sim_tdm_cpu_port.sv
module sim_tdm_cpu_port;
  logic       clk = 0, rst = 1;
  logic       cs_n = 1, ds = 0, rd_wr = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic       dta_n, msg_mode;
  logic       dm_we = 0;
  logic [8:0] dm_waddr = 0;
  logic [7:0] dm_wdata = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tdm_cpu_port u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rd_wr(rd_wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dta_n(dta_n), .msg_mode(msg_mode),
    .dm_we(dm_we), .dm_waddr(dm_waddr), .dm_wdata(dm_wdata)
  );

  // behavioural reference model
  logic [7:0] m_reg [4];
  logic [7:0] m_dm [512];
  logic [7:0] m_cl [512];
  logic [7:0] m_ch [512];
  bit         busy_m = 0, rd_pend = 0;
  logic [7:0] exp_rd = 0;

  initial for (int i = 0; i < 512; i++) begin m_dm[i] = 0; m_cl[i] = 0; m_ch[i] = 0; end
  initial for (int i = 0; i < 4; i++) m_reg[i] = 0;

  function automatic int chan_limit();
    case (m_reg[1][1:0])
      2'b00:   return 32;
      2'b01:   return 64;
      default: return 128;
    endcase
  endfunction

  function automatic logic [7:0] f_read(input logic [7:0] a);
    int c, idx;
    if (!a[5]) return (a[4:0] < 4) ? m_reg[a[1:0]] : 8'h00;
    c = {a[7:6], a[4:0]};
    if (c >= chan_limit()) return 8'h00;
    idx = int'(m_reg[0][1:0]) * 128 + c;
    if (m_reg[0][7]) return m_dm[idx];
    case (m_reg[0][5:4])
      2'b00:   return m_dm[idx];
      2'b10:   return m_cl[idx];
      2'b11:   return m_ch[idx];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int c, idx;
    if (!a[5]) begin
      if (a[4:0] < 4) m_reg[a[1:0]] = d;
    end else begin
      c = {a[7:6], a[4:0]};
      idx = int'(m_reg[0][1:0]) * 128 + c;
      if (c < chan_limit()) begin
        if (m_reg[0][7]) m_cl[idx] = d;
        else if (m_reg[0][5:4] == 2'b10) m_cl[idx] = d;
        else if (m_reg[0][5:4] == 2'b11) m_ch[idx] = d;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      busy_m <= 0; rd_pend <= 0;
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
    end else begin
      if (!cs_n && ds && !busy_m) begin
        busy_m  <= 1;
        rd_pend <= rd_wr;
        if (rd_wr) exp_rd <= f_read(addr);
        else model_write(addr, wdata);
      end else if (!(!cs_n && ds)) begin
        busy_m <= 0;
      end
      if (dm_we) m_dm[dm_waddr] = dm_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(dta_n == !busy_m, "R10 acknowledge vs model", dta_n, !busy_m);
      chk(msg_mode == m_reg[0][6], "R6 msg_mode vs model", msg_mode, m_reg[0][6]);
      if (busy_m && rd_pend) chk(rdata == exp_rd, "R2 read data vs model", rdata, exp_rd);
    end
  end

  task automatic acc(input logic rd, input logic [7:0] a, input logic [7:0] d, output logic [7:0] v);
    @(negedge clk);
    chk(dta_n == 1'b1, "R10 idle before strobe", dta_n, 1);
    addr = a; rd_wr = rd; wdata = d; cs_n = 0; ds = 1;
    @(negedge clk);
    chk(dta_n == 1'b0, "R10 ack one clock after strobe", dta_n, 0);
    v = rdata;
    @(negedge clk);
    chk(dta_n == 1'b0 && rdata == v, "R10 ack held with stable data", dta_n, 0);
    cs_n = 1; ds = 0;
    @(negedge clk);
    chk(dta_n == 1'b1, "R10 release after strobe", dta_n, 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] v;
    acc(0, a, d, v);
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    acc(1, a, 8'h00, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic fill(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    dm_we = 1; dm_waddr = a; dm_wdata = d;
    @(negedge clk);
    dm_we = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dta_n == 1 && msg_mode == 0, "R11 reset outputs", {dta_n, msg_mode}, 2);
    for (int i = 0; i < 4; i++) rdchk(8'(i), 8'h00, "R11 register cleared");

    wr(8'h01, 8'h02); wr(8'h02, 8'h5A); wr(8'h03, 8'hC3);
    rdchk(8'hC1, 8'h02, "R1 interface mode with bits 7..6 set");
    rdchk(8'h02, 8'h5A, "R1 stream pair register");
    rdchk(8'h83, 8'hC3, "R1 frame offset register");

    wr(8'h05, 8'h77);
    rdchk(8'h05, 8'h00, "R7 unused register reads zero");
    rdchk(8'h01, 8'h02, "R7 unused write left registers alone");
    rdchk(8'h1F, 8'h00, "R7 top unused register");

    fill(9'h003, 8'h11); fill(9'h083, 8'h22); fill(9'h064, 8'h33);

    wr(8'h00, 8'h20); wr(8'h23, 8'hA1);
    wr(8'h00, 8'h21); wr(8'h23, 8'hB2);
    wr(8'h00, 8'h30); wr(8'h23, 8'hC4);
    wr(8'h00, 8'h20); rdchk(8'h23, 8'hA1, "R2 low connection store");
    wr(8'h00, 8'h21); rdchk(8'h23, 8'hB2, "R3 stream 1 subsection");
    wr(8'h00, 8'h30); rdchk(8'h23, 8'hC4, "R2 high connection store");

    wr(8'h00, 8'h00); rdchk(8'h23, 8'h11, "R4 data store read");
    wr(8'h23, 8'hEE); rdchk(8'h23, 8'h11, "R4 data store write ignored");
    wr(8'h00, 8'h01); rdchk(8'h23, 8'h22, "R3 data store stream 1");

    wr(8'h00, 8'h10); rdchk(8'h23, 8'h00, "R8 reserved select reads zero");
    wr(8'h23, 8'h99);
    wr(8'h00, 8'h20); rdchk(8'h23, 8'hA1, "R8 reserved write left low store");
    wr(8'h00, 8'h30); rdchk(8'h23, 8'hC4, "R8 reserved write left high store");

    wr(8'h00, 8'hB0); rdchk(8'h23, 8'h11, "R5 split read from data store");
    wr(8'h23, 8'h5F);
    wr(8'h00, 8'h20); rdchk(8'h23, 8'h5F, "R5 split write to low store");
    wr(8'h00, 8'h30); rdchk(8'h23, 8'hC4, "R5 split write missed high store");

    wr(8'h00, 8'h60);
    chk(msg_mode == 1, "R6 message on", msg_mode, 1);
    wr(8'h00, 8'h20);
    chk(msg_mode == 0, "R6 message off", msg_mode, 0);

    wr(8'hE4, 8'h4D); rdchk(8'hE4, 8'h4D, "R9 channel 100 at full rate");
    wr(8'h00, 8'h00); rdchk(8'hE4, 8'h33, "R2 channel from bits 7..6 and 4..0");
    wr(8'h00, 8'h20);
    wr(8'h01, 8'h01); rdchk(8'hE4, 8'h00, "R9 channel 100 beyond 64");
    wr(8'h68, 8'h6B); rdchk(8'h68, 8'h6B, "R9 channel 40 within 64");
    wr(8'h01, 8'h00); rdchk(8'h68, 8'h00, "R9 channel 40 beyond 32");
    wr(8'h68, 8'h7C);
    wr(8'h3F, 8'h1F); rdchk(8'h3F, 8'h1F, "R9 channel 31 within 32");
    wr(8'h01, 8'h01); rdchk(8'h68, 8'h6B, "R9 out-of-range write ignored");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule